// File: doc/BRIEF.md
# XGMII Receive Error Monitor

This block sits on the receive side of a 10-gigabit link. It watches the parallel receive stream, which carries one eight-lane column per clock with a data octet and a control bit for each lane. It classifies line anomalies into three counters. Symbol errors are error characters that arrive inside a frame, and they are counted at most once per frame. Data errors are framing faults on the data path: a Start in the wrong lane, a preamble or SFD that is broken, a control character where data or a specific control was expected, and a Start that arrives in the middle of a frame. Control errors are stray control characters on an idle line.

The block keeps a small frame-tracking state machine (idle, in frame, and a one-column SFD check that follows a Start in the upper half of the column). The state machine decides which counter an anomaly belongs to. Every column is classified in full in the cycle it arrives. For each class there is a one-cycle event pulse, and the three 64-bit totals can be read through a select-and-read port. A synchronous clear strobe zeroes the totals.

Top module: `xgmii_rx_err_mon`

## Requirements
- R1: A control-flagged 0xFE (error character) inside the frame window raises the symbol count by one. Further error characters in the same frame add nothing.
- R2: The symbol window runs from the Start lane through the Terminate lane, both included. Error characters before a Start or after a Terminate never change the symbol count.
- R3: A Start is accepted only in lane 0 or lane 4, and lane 0 wins when both lanes carry one. A Start in any other lane while idle is a data error, and no frame is entered.
- R4: After a lane-0 Start, lanes 1 to 6 must hold data and lane 7 must hold data 0xD5. After a lane-4 Start, lanes 5 to 7 must hold data, and the next column must hold data in lanes 0 to 2 and data 0xD5 in lane 3. Any violation is a data error.
- R5: Inside a frame, any control character other than Error, Terminate or Start (for example Idle 0x07) is a data error.
- R6: A Start inside a frame before any Terminate is a data error and restarts the frame. The once-per-frame symbol limit is re-armed for the lanes after that Start, and the restarted frame gets no SFD check.
- R7: Outside a frame, which means on an idle line, before an accepted Start, or after a Terminate in the same column, every control character other than Idle is a control error. Starts on an idle line are the exception and count under R3. A Start after a Terminate in the same column is a control error and is not accepted.
- R8: Each counter rises by at most one per column. Its pulse is high for one cycle, in the cycle after the column is sampled, and the new count can be read in that same cycle.
- R9: Lane j is rx_data[8j+7:8j], and rx_ctrl[j] is its control flag. The control codes are Start 0xFB, Terminate 0xFD, Idle 0x07 and Error 0xFE. The SFD is data 0xD5.
- R10: rd_sel selects the value on rd_data with no delay: 0 gives the symbol count, 1 the data count, 2 the control count and 3 zero.
- R11: While clear is high, all three counts become zero at the clock edge, even if an event occurs in the same column. Pulses and frame tracking are not affected.
- R12: Reset leaves all counts at zero, all pulses low and the tracker idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_data | input | 64 | Receive octets, lane 0 in the low byte |
| rx_ctrl | input | 8 | Per-lane control flags |
| clear | input | 1 | Synchronous clear of all three counts |
| rd_sel | input | 2 | Count select for rd_data |
| rd_data | output | 64 | Selected count |
| sym_err_pulse | output | 1 | Symbol error event |
| data_err_pulse | output | 1 | Data-path framing error event |
| ctrl_err_pulse | output | 1 | Stray control character event |

## Verification
Two classes can land in one column, and the bench provokes this on purpose. In the first case an in-frame column carries an error character in one lane and an Idle in another, so the symbol and data pulses must rise together and each count must step by exactly one. In the second case a Terminate splits a column: an Idle sits before the Terminate and a non-Idle control sits after it, which must raise the data and control pulses in the same cycle. Both cases are judged per column by the pulse scoreboard and then again through the read port against running totals.

// File: rtl/xem_pkg.sv
package xem_pkg;

  localparam logic [7:0] CODE_START = 8'hFB;
  localparam logic [7:0] CODE_TERM  = 8'hFD;
  localparam logic [7:0] CODE_IDLE  = 8'h07;
  localparam logic [7:0] CODE_ERROR = 8'hFE;
  localparam logic [7:0] CODE_SFD   = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FRAME  = 2'd1,
    ST_SFDCHK = 2'd2
  } frm_state_e;

  typedef struct packed {
    logic ctl;
    logic dat;
    logic sym;
  } err_evt_t;

endpackage

// File: rtl/xem_lane_decode.sv
module xem_lane_decode
  import xem_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0] rx_data,
  input  logic [LANES-1:0]   rx_ctrl,
  output logic [LANES-1:0]   is_start,
  output logic [LANES-1:0]   is_term,
  output logic [LANES-1:0]   is_idle,
  output logic [LANES-1:0]   is_err,
  output logic [LANES-1:0]   is_sfd
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] octet;
    assign octet       = rx_data[8*g +: 8];
    assign is_start[g] = rx_ctrl[g] && (octet == CODE_START);
    assign is_term[g]  = rx_ctrl[g] && (octet == CODE_TERM);
    assign is_idle[g]  = rx_ctrl[g] && (octet == CODE_IDLE);
    assign is_err[g]   = rx_ctrl[g] && (octet == CODE_ERROR);
    assign is_sfd[g]   = !rx_ctrl[g] && (octet == CODE_SFD);
  end

endmodule

// File: rtl/xem_frame_fsm.sv
module xem_frame_fsm
  import xem_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] ctl,
  input  logic [LANES-1:0] is_start,
  input  logic [LANES-1:0] is_term,
  input  logic [LANES-1:0] is_idle,
  input  logic [LANES-1:0] is_err,
  input  logic [LANES-1:0] is_sfd,
  output err_evt_t         evt
);

  localparam int HALF = LANES / 2;
  localparam logic [LANES-1:0] ONE      = {{(LANES-1){1'b0}}, 1'b1};
  localparam logic [LANES-1:0] LOW_HALF = (ONE << HALF) - ONE;
  localparam logic [LANES-1:0] TOP_LANE = ONE << (LANES-1);
  localparam logic [LANES-1:0] SFD_HALF = ONE << (HALF-1);
  localparam logic [LANES-1:0] PRE_HALF = ~((ONE << (HALF+1)) - ONE);
  localparam logic [LANES-1:0] ALIGNED  = ONE | (ONE << HALF);

  // lowest set lane as one-hot
  function automatic logic [LANES-1:0] lowest(input logic [LANES-1:0] v);
    return v & (~v + ONE);
  endfunction

  // lanes at or below the lowest set lane; all lanes when none set
  function automatic logic [LANES-1:0] upto_first(input logic [LANES-1:0] v);
    logic [LANES-1:0] lo;
    lo = lowest(v);
    return lo | (lo - ONE);
  endfunction

  // lanes strictly below the lowest set lane; all lanes when none set
  function automatic logic [LANES-1:0] below_first(input logic [LANES-1:0] v);
    return lowest(v) - ONE;
  endfunction

  frm_state_e state_q, state_n;
  logic       seen_q, seen_n;

  // idle-state classification
  logic             go_lo, go_hi;
  logic [LANES-1:0] idle_out;
  logic             i_ctl, i_dat, i_sym;

  assign go_lo    = is_start[0];
  assign go_hi    = is_start[HALF] & ~is_start[0];
  assign idle_out = go_lo ? '0 : (go_hi ? LOW_HALF : '1);
  assign i_ctl    = |(ctl & ~is_idle & ~is_start & idle_out);
  assign i_dat    = (|(is_start & idle_out))
                  | (go_lo & ((|(ctl & ~ONE)) | (|(TOP_LANE & ~is_sfd))))
                  | (go_hi & (|(ctl & PRE_HALF)));
  assign i_sym    = |(is_err & ~idle_out);

  // in-frame classification
  logic [LANES-1:0] win, start_in, old_m, new_m;
  logic             f_restart, f_sym_old, f_sym_new, f_dat, f_ctl, f_sfd_bad;

  assign win       = upto_first(is_term);
  assign start_in  = is_start & win;
  assign f_restart = |start_in;
  assign old_m     = win & below_first(start_in);
  assign new_m     = win & ~upto_first(start_in);
  assign f_sym_old = (|(is_err & old_m)) & ~seen_q;
  assign f_sym_new = |(is_err & new_m);
  assign f_sfd_bad = (|(ctl & LOW_HALF)) | (|(SFD_HALF & ~is_sfd));
  assign f_dat     = f_restart
                   | (|(ctl & win & ~is_err & ~is_term & ~is_start))
                   | ((state_q == ST_SFDCHK) & f_sfd_bad);
  assign f_ctl     = |(ctl & ~win & ~is_idle);

  always_comb begin
    state_n = state_q;
    seen_n  = seen_q;
    evt     = '0;
    case (state_q)
      ST_IDLE: begin
        evt.ctl = i_ctl;
        evt.dat = i_dat;
        evt.sym = i_sym;
        if (go_lo) begin
          state_n = ST_FRAME;
          seen_n  = i_sym;
        end else if (go_hi) begin
          state_n = ST_SFDCHK;
          seen_n  = i_sym;
        end
      end
      default: begin
        evt.ctl = f_ctl;
        evt.dat = f_dat;
        evt.sym = f_sym_old | f_sym_new;
        seen_n  = f_restart ? f_sym_new : (seen_q | f_sym_old);
        state_n = (|is_term) ? ST_IDLE : ST_FRAME;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      seen_q  <= seen_n;
    end
  end

  assert_once_per_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && seen_q && !(|is_start)) |-> !evt.sym);

  assert_sym_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !is_start[0] && !is_start[HALF]) |-> !evt.sym);

  assert_misplaced_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && (|(is_start & ~ALIGNED))) |-> evt.dat);

  assert_sfd_single_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SFDCHK) |=> (state_q != ST_SFDCHK));

  assert_no_ctrl_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !(|is_term)) |-> !evt.ctl);

endmodule

// File: rtl/xem_counter.sv
module xem_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_n;

  always_comb begin
    count_n = count;
    if (clr) begin
      count_n = '0;
    end else if (inc) begin
      count_n = count + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_n;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));

  assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (count == $past(count) + 1'b1));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/xgmii_rx_err_mon.sv
module xgmii_rx_err_mon
  import xem_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8*LANES-1:0] rx_data,
  input  logic [LANES-1:0]   rx_ctrl,
  input  logic               clear,
  input  logic [1:0]         rd_sel,
  output logic [CNT_W-1:0]   rd_data,
  output logic               sym_err_pulse,
  output logic               data_err_pulse,
  output logic               ctrl_err_pulse
);

  localparam int NCNT = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic [LANES-1:0] is_start, is_term, is_idle, is_err, is_sfd;
  err_evt_t         evt;

  xem_lane_decode #(.LANES(LANES)) u_dec (
    .rx_data  (rx_data),
    .rx_ctrl  (rx_ctrl),
    .is_start (is_start),
    .is_term  (is_term),
    .is_idle  (is_idle),
    .is_err   (is_err),
    .is_sfd   (is_sfd)
  );

  xem_frame_fsm #(.LANES(LANES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctl      (rx_ctrl),
    .is_start (is_start),
    .is_term  (is_term),
    .is_idle  (is_idle),
    .is_err   (is_err),
    .is_sfd   (is_sfd),
    .evt      (evt)
  );

  logic [NCNT-1:0]  ev_vec;
  logic [CNT_W-1:0] cnt [NCNT];

  assign ev_vec = {evt.ctl, evt.dat, evt.sym};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    xem_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (clear),
      .inc   (ev_vec[g]),
      .count (cnt[g])
    );
  end

  logic [NCNT-1:0] pulse_q, pulse_n;

  always_comb begin
    pulse_n = ev_vec;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= pulse_n;
    end
  end

  assign sym_err_pulse  = pulse_q[0];
  assign data_err_pulse = pulse_q[1];
  assign ctrl_err_pulse = pulse_q[2];

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = cnt[0];
      2'd1:    rd_data = cnt[1];
      2'd2:    rd_data = cnt[2];
      default: rd_data = '0;
    endcase
  end

  assert_pulse_low_in_reset_R12: assert property (@(posedge clk)
    !rst_int_n |-> (pulse_q == '0));

endmodule

// File: tb/sim_xgmii_rx_err_mon.sv
module sim_xgmii_rx_err_mon;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] rx_data;
  logic [7:0]  rx_ctrl;
  logic        clear;
  logic [1:0]  rd_sel;
  logic [63:0] rd_data;
  logic        sym_err_pulse, data_err_pulse, ctrl_err_pulse;

  always #5 clk = ~clk;

  xgmii_rx_err_mon u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_data        (rx_data),
    .rx_ctrl        (rx_ctrl),
    .clear          (clear),
    .rd_sel         (rd_sel),
    .rd_data        (rd_data),
    .sym_err_pulse  (sym_err_pulse),
    .data_err_pulse (data_err_pulse),
    .ctrl_err_pulse (ctrl_err_pulse)
  );

  localparam logic [63:0] D_IDLE   = 64'h0707070707070707;
  localparam logic [63:0] D_ST0    = 64'hD5555555555555FB;
  localparam logic [63:0] D_ST4    = 64'h555555FB07070707;
  localparam logic [63:0] D_SFD4   = 64'hAAAAAAAAD5555555;
  localparam logic [63:0] D_BODY   = 64'h1122334455667788;
  localparam logic [63:0] D_TERM1  = 64'h070707070707FD99;

  int checks = 0;
  int fails  = 0;
  logic [2:0]  exp_q[$];
  string       tag_q[$];
  logic [63:0] m_sym, m_dat, m_ctl;
  bit          mon_en = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // e = {ctrl, data, sym} pulses expected for this column
  task automatic send(input logic [63:0] d, input logic [7:0] c, input logic [2:0] e,
                      input string tag, input logic clr = 1'b0);
    @(negedge clk);
    rx_data = d;
    rx_ctrl = c;
    clear   = clr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (clr) begin
      m_sym = '0; m_dat = '0; m_ctl = '0;
    end else begin
      m_sym = m_sym + e[0];
      m_dat = m_dat + e[1];
      m_ctl = m_ctl + e[2];
    end
  endtask

  task automatic regs(input string tag);
    send(D_IDLE, 8'hFF, 3'b000, tag);
    rd_sel = 2'd0; #1 chk({tag, " symbol count"}, rd_data, m_sym);
    rd_sel = 2'd1; #1 chk({tag, " data count"}, rd_data, m_dat);
    rd_sel = 2'd2; #1 chk({tag, " control count"}, rd_data, m_ctl);
  endtask

  always @(posedge clk) begin : mon
    logic [2:0] e;
    string t;
    #2;
    if (mon_en && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " pulses"}, {61'd0, ctrl_err_pulse, data_err_pulse, sym_err_pulse}, {61'd0, e});
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; rd_sel = 2'd0;
    rx_data = D_IDLE; rx_ctrl = 8'hFF;
    m_sym = '0; m_dat = '0; m_ctl = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pulses in reset", {61'd0, ctrl_err_pulse, data_err_pulse, sym_err_pulse}, 64'd0);
    rd_sel = 2'd0; #1 chk("R12 symbol count in reset", rd_data, 64'd0);
    rd_sel = 2'd1; #1 chk("R12 data count in reset", rd_data, 64'd0);
    rd_sel = 2'd2; #1 chk("R12 control count in reset", rd_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R9 clean frame, lane-0 Start
    send(D_ST0,   8'h01, 3'b000, "R9 lane0 start");
    send(D_BODY,  8'h00, 3'b000, "R9 body");
    send(D_TERM1, 8'hFE, 3'b000, "R9 terminate");
    // R4 clean frame, lane-4 Start
    send(D_ST4,   8'h1F, 3'b000, "R4 lane4 start");
    send(D_SFD4,  8'h00, 3'b000, "R4 lane4 sfd ok");
    send(D_TERM1, 8'hFE, 3'b000, "R4 terminate");
    regs("R12 after clean frames");

    // R1 several error characters, counted once
    send(D_ST0,   8'h01, 3'b000, "R1 start");
    send(64'h1122FE4455FE7788, 8'h24, 3'b001, "R1 two errors");
    send(64'h11223344556677FE, 8'h01, 3'b000, "R1 repeat error");
    send(D_TERM1, 8'hFE, 3'b000, "R1 terminate");
    // R2 error in the Terminate column before the Terminate lane
    send(D_ST0,   8'h01, 3'b000, "R2 start");
    send(64'h070707070707FDFE, 8'hFF, 3'b001, "R2 error at terminate column");
    // R2/R7 error characters outside the window
    send(64'h07070707FE070707, 8'hFF, 3'b100, "R2 error while idle");
    send(D_ST0,   8'h01, 3'b000, "R2 start");
    send(64'h0707070707FE07FD, 8'hFF, 3'b100, "R2 error after terminate");
    regs("R1 R2 totals");

    // R3 misplaced Start while idle
    send(64'h5555555555FB0707, 8'h07, 3'b010, "R3 start in lane 2");
    send(D_BODY,  8'h00, 3'b000, "R3 data while idle ignored");
    // R3 both aligned lanes carry Start: lane 0 wins, lane 4 breaks the preamble
    send(64'hD55555FB555555FB, 8'h11, 3'b010, "R3 double start");
    send(D_TERM1, 8'hFE, 3'b000, "R3 terminate");
    // R4 bad SFD, lane 0
    send(64'h55555555555555FB, 8'h01, 3'b010, "R4 lane0 bad sfd");
    send(D_TERM1, 8'hFE, 3'b000, "R4 terminate");
    // R4 bad SFD, lane 4
    send(D_ST4,   8'h1F, 3'b000, "R4 lane4 start");
    send(64'hAAAAAAAA55555555, 8'h00, 3'b010, "R4 lane4 bad sfd");
    send(D_TERM1, 8'hFE, 3'b000, "R4 terminate");
    // R5 Idle inside a frame
    send(D_ST0,   8'h01, 3'b000, "R5 start");
    send(64'h1122334407667788, 8'h08, 3'b010, "R5 idle in frame");
    send(D_TERM1, 8'hFE, 3'b000, "R5 terminate");
    regs("R3 R4 R5 totals");

    // R6 restart re-arms the symbol limit
    send(D_ST0,   8'h01, 3'b000, "R6 start");
    send(64'h1122FE4455FE7788, 8'h24, 3'b001, "R6 error old frame");
    send(64'h11223344556677FB, 8'h01, 3'b010, "R6 restart");
    send(64'h11223344556677FE, 8'h01, 3'b001, "R6 error new frame");
    send(D_TERM1, 8'hFE, 3'b000, "R6 terminate");
    // R8 symbol and data in one column
    send(D_ST0,   8'h01, 3'b000, "R8 start");
    send(64'h112207445566FE88, 8'h22, 3'b011, "R8 symbol and data together");
    // R8 data and control in one column, split by Terminate
    send(64'h07079C0707FD0788, 8'hFE, 3'b110, "R8 data and control together");
    // R7 Start after Terminate in the same column is stray
    send(D_ST0,   8'h01, 3'b000, "R7 start");
    send(64'h555555FB070707FD, 8'h1F, 3'b100, "R7 start after terminate");
    send(D_BODY,  8'h00, 3'b000, "R7 not in frame afterwards");
    regs("R6 R7 R8 totals");

    // R11 clear wins over a same-column event
    send(64'h07070707FE070707, 8'hFF, 3'b100, "R11 clear with event", 1'b1);
    regs("R11 after clear");
    send(64'h07070707FE070707, 8'hFF, 3'b100, "R11 event after clear");
    regs("R11 counting resumes");
    // R10 select 3 reads zero
    rd_sel = 2'd3; #1 chk("R10 select 3", rd_data, 64'd0);

    send(D_IDLE, 8'hFF, 3'b000, "R12 final idle");
    @(posedge clk); #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule